// File: doc/BRIEF.md
# Pixel Dump Capture Sequencer

This block pulls one complete raw image out of an optical motion sensor and stores it in a local byte buffer. It works through a register master. The master takes one command at a time: a read or a write, with an address and write data. It answers every command, writes included, with a single response beat. A capture is started by a one-cycle strobe. The sequencer first writes the sensor's configuration register with two bits set: one keeps the sensor awake and the other puts it in image-readout mode. It then polls in a loop. Each attempt reads the upper data-out register and then the lower one. Only the lower byte is pixel data. When the top bit of the lower byte is set, the sample is not ready, and the attempt is repeated without moving on to the next pixel.

Good samples land in the buffer at indices 0, 1, 2 and so on. When the index passes its last value and wraps to zero, the image is complete. The sequencer then writes zero to the configuration register and gives a one-cycle done pulse.

A guard ends the capture if a run of not-ready samples reaches a limit set on a port. The configuration register is still cleared in that case, and the done pulse carries an error flag. A limit of zero turns the guard off.

The state machine has nine states: IDLE, ARM_REQ, ARM_RSP, HI_REQ, HI_RSP, LO_REQ, LO_RSP, OFF_REQ and OFF_RSP.
- IDLE goes to ARM_REQ on `start`.
- Each *_REQ state moves to its *_RSP state when the master accepts the command (`cmd_valid && cmd_ready`).
- ARM_RSP goes to HI_REQ when the response arrives.
- HI_RSP goes to LO_REQ when the response arrives.
- LO_RSP, on its response, goes back to HI_REQ for a new attempt. It goes to OFF_REQ instead when the last pixel has been stored or the not-ready limit has been reached.
- OFF_RSP returns to IDLE on its response and raises `done`.

Top module: `pixdump_seq`

## Requirements
- R1: A `start` pulse in IDLE issues, as the first command, a write to address CFG_ADDR (default 0x0A). Its data has bit NOSLEEP_BIT (default 0) and bit DUMP_BIT (default 3) set and all other bits clear, which gives 0x09 by default.
- R2: Each poll attempt is a read of UP_ADDR (default 0x0C) followed directly by a read of LO_ADDR (default 0x0D). No read of LO_ADDR happens without the UP_ADDR read just before it. The upper byte is never stored.
- R3: A lower byte with bit 7 set is a not-ready sample. It causes no buffer write and does not advance the pixel index, and a new attempt follows.
- R4: Ready samples are written with `buf_we` at `buf_addr` 0, 1, 2 … in order. `buf_wdata` equals the lower byte returned by the master.
- R5: After the PIX_COUNT-th ready sample (256 by default) the block writes 0x00 to CFG_ADDR. It pulses `done` for exactly one cycle, with `err` low, in the cycle that the response to that write is presented.
- R6: When `poll_limit` is nonzero and `poll_limit` consecutive not-ready samples arrive, the capture aborts. It writes 0x00 to CFG_ADDR and pulses `done` with `err` high. When `poll_limit` is 0, there is no limit.
- R7: A `start` received while a capture is in progress is ignored: there is no second configuration write and no extra `done`.
- R8: The block has at most one command outstanding. A command that is offered but not accepted keeps the same address and data until it is accepted.
- R9: While reset is held, `cmd_valid`, `buf_we` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle capture request |
| poll_limit | input | LIM_W | Consecutive not-ready samples that abort the capture (0 = no limit) |
| cmd_valid | output | 1 | Command offered to the register master |
| cmd_ready | input | 1 | Master accepts the command |
| cmd_write | output | 1 | 1 = write, 0 = read |
| cmd_addr | output | ADDR_W | Register address |
| cmd_wdata | output | DATA_W | Write data |
| rsp_valid | input | 1 | Response beat from the master |
| rsp_data | input | DATA_W | Read data returned |
| buf_we | output | 1 | Buffer write enable |
| buf_addr | output | IDX_W | Buffer write index |
| buf_wdata | output | DATA_W | Pixel byte to store |
| done | output | 1 | Capture finished (one cycle) |
| err | output | 1 | Valid with `done`: capture aborted |

## Verification
Some behaviours are checked on every cycle by assertions:
- an unaccepted command holds steady;
- a buffer write occurs only on a ready lower byte;
- the index steps by one on each store;
- the run of not-ready samples never goes past the limit;
- a `start` during a capture does not restart the machine;
- `done` lasts a single cycle.

Other behaviours only the bench's scenarios can show: the exact order of commands, the values in the configuration writes, the buffer contents after a full image, and the pixel count and error flag at the abort boundary (a run of exactly the limit length against one shorter, and a limit of one).

// File: rtl/pixdump_pkg.sv
package pixdump_pkg;
    typedef enum logic [3:0] {
        S_IDLE,
        S_ARM_REQ,
        S_ARM_RSP,
        S_HI_REQ,
        S_HI_RSP,
        S_LO_REQ,
        S_LO_RSP,
        S_OFF_REQ,
        S_OFF_RSP
    } state_e;
endpackage

// File: rtl/pixdump_cnt.sv
module pixdump_cnt #(
    parameter int PIX_COUNT = 256,
    parameter int LIM_W     = 16,
    localparam int IDX_W    = $clog2(PIX_COUNT)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             pix_inc,
    input  logic             miss_inc,
    input  logic [LIM_W-1:0] poll_limit,
    output logic [IDX_W-1:0] idx,
    output logic             last_pix,
    output logic             limit_hit
);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(PIX_COUNT - 1);

    logic [LIM_W-1:0] miss_cnt;
    logic [LIM_W:0]   miss_next;

    assign last_pix  = (idx == IDX_LAST);
    assign miss_next = {1'b0, miss_cnt} + 1'b1;
    assign limit_hit = (poll_limit != '0) && (miss_next >= {1'b0, poll_limit});

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            idx      <= '0;
            miss_cnt <= '0;
        end else begin
            if (pix_inc) begin
                idx      <= last_pix ? '0 : idx + 1'b1;
                miss_cnt <= '0;
            end else if (miss_inc && miss_cnt != '1) begin
                miss_cnt <= miss_cnt + 1'b1;
            end
        end
    end

    AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_inc && !clr && !last_pix) |=> (idx == IDX_W'($past(idx) + 1'b1))); // R4

    AST_MISS_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (poll_limit != '0 && $stable(poll_limit)) |-> (miss_cnt <= poll_limit)); // R6
endmodule

// File: rtl/pixdump_fsm.sv
module pixdump_fsm
    import pixdump_pkg::*;
#(
    parameter int              ADDR_W      = 8,
    parameter int              DATA_W      = 8,
    parameter logic [ADDR_W-1:0] CFG_ADDR  = 8'h0A,
    parameter logic [ADDR_W-1:0] UP_ADDR   = 8'h0C,
    parameter logic [ADDR_W-1:0] LO_ADDR   = 8'h0D,
    parameter int              NOSLEEP_BIT = 0,
    parameter int              DUMP_BIT    = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              cmd_ready,
    input  logic              rsp_valid,
    input  logic              rsp_invalid,
    input  logic              last_pix,
    input  logic              limit_hit,
    output logic              cmd_valid,
    output logic              cmd_write,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic [DATA_W-1:0] cmd_wdata,
    output logic              clr,
    output logic              pix_inc,
    output logic              miss_inc,
    output logic              done,
    output logic              err
);
    localparam logic [DATA_W-1:0] ARM_VAL =
        DATA_W'((1 << NOSLEEP_BIT) | (1 << DUMP_BIT));

    state_e state, state_nx;
    logic   abort_q;
    logic   lo_hit;

    assign lo_hit = (state == S_LO_RSP) && rsp_valid;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= S_IDLE;
            abort_q <= 1'b0;
        end else begin
            state <= state_nx;
            if (state == S_IDLE && start)
                abort_q <= 1'b0;
            else if (lo_hit && rsp_invalid && limit_hit)
                abort_q <= 1'b1;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:    if (start)     state_nx = S_ARM_REQ;
            S_ARM_REQ: if (cmd_ready) state_nx = S_ARM_RSP;
            S_ARM_RSP: if (rsp_valid) state_nx = S_HI_REQ;
            S_HI_REQ:  if (cmd_ready) state_nx = S_HI_RSP;
            S_HI_RSP:  if (rsp_valid) state_nx = S_LO_REQ;
            S_LO_REQ:  if (cmd_ready) state_nx = S_LO_RSP;
            S_LO_RSP: begin
                if (rsp_valid) begin
                    if (rsp_invalid)
                        state_nx = limit_hit ? S_OFF_REQ : S_HI_REQ;
                    else
                        state_nx = last_pix ? S_OFF_REQ : S_HI_REQ;
                end
            end
            S_OFF_REQ: if (cmd_ready) state_nx = S_OFF_RSP;
            S_OFF_RSP: if (rsp_valid) state_nx = S_IDLE;
            default:   state_nx = S_IDLE;
        endcase
    end

    always_comb begin
        cmd_valid = 1'b0;
        cmd_write = 1'b0;
        cmd_addr  = '0;
        cmd_wdata = '0;
        unique case (state)
            S_ARM_REQ: begin
                cmd_valid = 1'b1;
                cmd_write = 1'b1;
                cmd_addr  = CFG_ADDR;
                cmd_wdata = ARM_VAL;
            end
            S_HI_REQ: begin
                cmd_valid = 1'b1;
                cmd_addr  = UP_ADDR;
            end
            S_LO_REQ: begin
                cmd_valid = 1'b1;
                cmd_addr  = LO_ADDR;
            end
            S_OFF_REQ: begin
                cmd_valid = 1'b1;
                cmd_write = 1'b1;
                cmd_addr  = CFG_ADDR;
            end
            default: ;
        endcase
        clr      = (state == S_IDLE) && start;
        pix_inc  = lo_hit && !rsp_invalid;
        miss_inc = lo_hit && rsp_invalid;
        done     = (state == S_OFF_RSP) && rsp_valid;
        err      = done && abort_q;
    end

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_ready) |=>
            (cmd_valid && $stable(cmd_addr) && $stable(cmd_wdata) && $stable(cmd_write))); // R8

    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (start && state != S_IDLE && state != S_ARM_REQ) |=> (state != S_ARM_REQ)); // R7

    AST_DONE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R5

    AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> done); // R6
endmodule

// File: rtl/pixdump_seq.sv
module pixdump_seq #(
    parameter int              PIX_COUNT   = 256,
    parameter int              ADDR_W      = 8,
    parameter int              DATA_W      = 8,
    parameter int              LIM_W       = 16,
    parameter logic [ADDR_W-1:0] CFG_ADDR  = 8'h0A,
    parameter logic [ADDR_W-1:0] UP_ADDR   = 8'h0C,
    parameter logic [ADDR_W-1:0] LO_ADDR   = 8'h0D,
    parameter int              NOSLEEP_BIT = 0,
    parameter int              DUMP_BIT    = 3,
    localparam int             IDX_W       = $clog2(PIX_COUNT)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [LIM_W-1:0]  poll_limit,
    output logic              cmd_valid,
    input  logic              cmd_ready,
    output logic              cmd_write,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic [DATA_W-1:0] cmd_wdata,
    input  logic              rsp_valid,
    input  logic [DATA_W-1:0] rsp_data,
    output logic              buf_we,
    output logic [IDX_W-1:0]  buf_addr,
    output logic [DATA_W-1:0] buf_wdata,
    output logic              done,
    output logic              err
);
    logic clr, pix_inc, miss_inc, last_pix, limit_hit;

    pixdump_fsm #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CFG_ADDR(CFG_ADDR),
        .UP_ADDR(UP_ADDR), .LO_ADDR(LO_ADDR),
        .NOSLEEP_BIT(NOSLEEP_BIT), .DUMP_BIT(DUMP_BIT)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .start(start),
        .cmd_ready(cmd_ready), .rsp_valid(rsp_valid),
        .rsp_invalid(rsp_data[DATA_W-1]),
        .last_pix(last_pix), .limit_hit(limit_hit),
        .cmd_valid(cmd_valid), .cmd_write(cmd_write),
        .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
        .clr(clr), .pix_inc(pix_inc), .miss_inc(miss_inc),
        .done(done), .err(err)
    );

    pixdump_cnt #(.PIX_COUNT(PIX_COUNT), .LIM_W(LIM_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .clr(clr),
        .pix_inc(pix_inc), .miss_inc(miss_inc), .poll_limit(poll_limit),
        .idx(buf_addr), .last_pix(last_pix), .limit_hit(limit_hit)
    );

    assign buf_we    = pix_inc;
    assign buf_wdata = rsp_data;

    AST_WE_READY_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        buf_we |-> (rsp_valid && !rsp_data[DATA_W-1])); // R3

    AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready) |=> !cmd_valid); // R8
endmodule

// File: tb/pixdump_seq_tb.sv
`timescale 1ns/1ps
module pixdump_seq_tb;
    localparam logic [7:0] CFG = 8'h0A, UP = 8'h0C, LO = 8'h0D, ARM = 8'h09;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic rst_n = 1'b0, start = 1'b0, cmd_ready = 1'b0, rsp_valid = 1'b0;
    logic [15:0] poll_limit = '0;
    logic [7:0] rsp_data = '0;
    logic cmd_valid, cmd_write, buf_we, done, err;
    logic [7:0] cmd_addr, cmd_wdata, buf_addr, buf_wdata;

    pixdump_seq u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .poll_limit(poll_limit),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_write(cmd_write),
        .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .buf_we(buf_we), .buf_addr(buf_addr), .buf_wdata(buf_wdata),
        .done(done), .err(err)
    );

    int checks = 0, fails = 0;
    int cyc = 0, lat_cnt = 0, mode = 0, att = 0, pix = 0, n_cmd = 0, scn = 0;
    int n_we = 0, bad_addr = 0, done_cnt = 0, lo_reads = 0, arm_cnt = 0, ord_err = 0;
    logic err_seen = 1'b0, first_ok = 1'b0, prev_hi = 1'b0, last_wr = 1'b0;
    logic [7:0] last_addr = '0, last_wdata = '0, pend = '0;
    logic [7:0] mem [256];

    function automatic logic [7:0] pix_val(int k, int s);
        return 8'((k * 37 + s * 11) & 8'h7F);
    endfunction

    function automatic bit not_ready(int m, int a, int p);
        case (m)
            1: return (a % 3) == 2;
            2: return p >= 10;
            3: return (a >= 5) && (a < 25);
            default: return 1'b0;
        endcase
    endfunction

    task automatic chk(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // register master model: drive after the rising edge
    always @(posedge clk) begin
        #1;
        cyc++;
        cmd_ready = (cyc % 3) != 0;
        rsp_valid = 1'b0;
        if (lat_cnt > 0) begin
            lat_cnt--;
            if (lat_cnt == 0) begin
                rsp_valid = 1'b1;
                rsp_data  = pend;
            end
        end
    end

    // monitor: sample at the falling edge
    always @(negedge clk) begin
        if (rst_n && cmd_valid && cmd_ready) begin
            n_cmd++;
            last_addr = cmd_addr;
            last_wr   = cmd_write;
            if (cmd_write) begin
                last_wdata = cmd_wdata;
                if (cmd_addr == CFG && cmd_wdata == ARM) arm_cnt++;
                if (n_cmd == 1) first_ok = (cmd_addr == CFG && cmd_wdata == ARM);
                pend = 8'h00;
                prev_hi = 1'b0;
            end else if (cmd_addr == UP) begin
                pend = 8'h80 | 8'(pix & 8'h7F);
                prev_hi = 1'b1;
            end else begin
                lo_reads++;
                if (!prev_hi) ord_err++;
                prev_hi = 1'b0;
                if (not_ready(mode, att, pix)) pend = 8'h80 | 8'(att & 8'h7F);
                else begin
                    pend = pix_val(pix, scn);
                    pix++;
                end
                att++;
            end
            lat_cnt = 1 + (n_cmd % 3);
        end
        if (rst_n && buf_we) begin
            if (int'(buf_addr) != (n_we % 256)) bad_addr++;
            mem[buf_addr] = buf_wdata;
            n_we++;
        end
        if (rst_n && done) begin
            done_cnt++;
            err_seen = err;
        end
    end

    task automatic run(int m, int lim, int exp_pix, int exp_att, bit exp_err);
        int w;
        bit mem_ok;
        scn++;
        mode = m; att = 0; pix = 0; n_cmd = 0; n_we = 0; bad_addr = 0;
        done_cnt = 0; lo_reads = 0; arm_cnt = 0; ord_err = 0;
        err_seen = 1'b0; first_ok = 1'b0; prev_hi = 1'b0;
        for (int k = 0; k < 256; k++) mem[k] = 8'hFF;
        @(posedge clk); #1; poll_limit = 16'(lim); start = 1'b1;
        @(posedge clk); #1; start = 1'b0;
        repeat (10) @(posedge clk);
        #1 start = 1'b1;                      // R7: ignored while busy
        @(posedge clk); #1; start = 1'b0;
        w = 0;
        while (done_cnt == 0 && w < 20000) begin
            @(posedge clk);
            w++;
        end
        chk(done_cnt != 0, "R5 watchdog", w, 20000);
        repeat (20) @(posedge clk);
        chk(first_ok, "R1 first command arm write", int'(first_ok), 1);
        chk(arm_cnt == 1 && done_cnt == 1, "R7 single capture", arm_cnt * 10 + done_cnt, 11);
        chk(ord_err == 0, "R2 upper read precedes lower", ord_err, 0);
        chk(lo_reads == exp_att, "R3 poll attempts", lo_reads, exp_att);
        chk(n_we == exp_pix, "R4 pixels stored", n_we, exp_pix);
        chk(bad_addr == 0, "R4 consecutive indices", bad_addr, 0);
        mem_ok = 1'b1;
        for (int k = 0; k < 256; k++)
            if (mem[k] != ((k < exp_pix) ? pix_val(k, scn) : 8'hFF)) mem_ok = 1'b0;
        chk(mem_ok, "R4 buffer contents", int'(mem_ok), 1);
        chk(last_wr && last_addr == CFG && last_wdata == 8'h00, "R5 final config clear",
            int'(last_wdata), 0);
        chk(err_seen == exp_err, exp_err ? "R6 abort flag" : "R5 clean finish",
            int'(err_seen), int'(exp_err));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(!cmd_valid && !buf_we && !done, "R9 reset outputs",
            int'({cmd_valid, buf_we, done}), 0);
        @(posedge clk); #1 rst_n = 1'b1;
        run(0, 0, 256, 256, 1'b0);   // all samples ready
        run(1, 0, 256, 383, 1'b0);   // every third attempt not ready
        run(2, 4, 10, 14, 1'b1);     // sensor stalls after 10 pixels
        run(3, 0, 256, 276, 1'b0);   // burst of 20, no limit
        run(3, 21, 256, 276, 1'b0);  // burst one short of limit
        run(3, 20, 5, 25, 1'b1);     // burst exactly at limit
        run(1, 1, 2, 3, 1'b1);       // limit of one
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #1000000;
        fails++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule